// File: doc/BRIEF.md
# Cache RAM clock ratio generator

This block derives the clock for an external synchronous cache RAM from the fast core clock. A 3-bit ratio code selects one of five divide ratios. Three are whole ratios (1, 2, 3) and two are half-integer ratios (1.5, 2.5). The remaining codes stop the RAM clock. Half-integer ratios are built from core half-periods: the output pattern is computed on rising core edges and completed by a falling-edge retiming flop. Each output period therefore spans 2, 3, 4, 5 or 6 core half-periods.

A code change is held back until the current output period has finished. This keeps the output free of runt pulses. When power saving is active (nap or sleep), the block does one of two things, depending on which enable is set. It can force the RAM clock low, or it can raise a sleep request (ZZ) toward the RAM. A lock-wait counter reports when a dividing ratio has been stable long enough for a downstream delay-lock loop to settle.

Top module: `ramclk_gen`

## Requirements
- R1: While reset is asserted and after its release with code 000, ramClk, divClkEn, ramZz, ratioValid, dllEn and clkStable are all low.
- R2: Code 000 stops the RAM clock: ramClk stays low and dllEn and ratioValid are low.
- R3: The output period in core half-periods is 2 for code 001, 3 for 010, 4 for 100, 5 for 101 and 6 for 110 (ratios 1, 1.5, 2, 2.5, 3).
- R4: Within each output period of H half-periods, ramClk is high for the first ceil(H/2) half-periods and low for the rest. A period that starts on a rising core edge has divClkEn high for that core cycle.
- R5: Reserved codes 011 and 111 behave as stopped: ramClk low, ratioValid low, dllEn low.
- R6: A new code takes effect at the first rising core edge that begins a new output period. The period in progress completes with the old pattern.
- R7: While a dividing code is in effect, ratioValid and dllEn are high.
- R8: With clkStopEn high and nap or sleep active, ramClk is forced low at once. It resumes when both modes end. With clkStopEn low, nap and sleep do not affect ramClk.
- R9: ramZz goes high one core cycle after zzEn is high with nap or sleep active, and low one cycle after that condition ends. With zzEn low, ramZz stays low.
- R10: clkStable rises after LOCK_CYCLES (default 64) consecutive core cycles with the same dividing code in effect. It is cleared when the code changes or the clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coreClk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioCode | input | 3 | Divide ratio code from the control register |
| clkStopEn | input | 1 | Gate RAM clock during nap or sleep |
| zzEn | input | 1 | Drive RAM sleep request during nap or sleep |
| napMode | input | 1 | Core is in nap |
| sleepMode | input | 1 | Core is in sleep |
| divClkEn | output | 1 | High for the core cycle that begins an output period |
| ramClk | output | 1 | Gated RAM clock |
| ramZz | output | 1 | RAM sleep request |
| ratioValid | output | 1 | A dividing code is in effect |
| dllEn | output | 1 | Delay-lock loop enable |
| clkStable | output | 1 | Lock-wait time has elapsed |

## Verification
A code change shows up at the next rising core edge with divClkEn set. ratioValid, dllEn and the first high half-period of the new pattern appear in that same cycle. The bench waits for that pulse and then samples ramClk in the middle of every following core half-period, so each sample falls in one known half-period of the pattern. Clock gating acts with zero latency and is sampled in the same half-period as the mode change. ramZz is sampled one rising edge after the mode change. clkStable is sampled well before and well after the 64-cycle window, counted from the rising edge that applied the code.

// File: rtl/ramclk_pkg.sv
package ramclk_pkg;
  localparam int CODE_W = 3;
  localparam int HALF_W = 3;

  typedef enum logic [CODE_W-1:0] {
    RC_OFF    = 3'b000,
    RC_DIV1   = 3'b001,
    RC_DIV1P5 = 3'b010,
    RC_RSV3   = 3'b011,
    RC_DIV2   = 3'b100,
    RC_DIV2P5 = 3'b101,
    RC_DIV3   = 3'b110,
    RC_RSV7   = 3'b111
  } ratioCode_e;

  typedef struct packed {
    logic              run;
    logic [HALF_W-1:0] halfLen;
    logic [HALF_W-1:0] highLen;
  } dpCtrl_t;

  // Output period length in core half-periods; zero means stopped.
  function automatic logic [HALF_W-1:0] halfLenOf(logic [CODE_W-1:0] code);
    case (ratioCode_e'(code))
      RC_DIV1:   return HALF_W'(2);
      RC_DIV1P5: return HALF_W'(3);
      RC_DIV2:   return HALF_W'(4);
      RC_DIV2P5: return HALF_W'(5);
      RC_DIV3:   return HALF_W'(6);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/ramclk_ctrl.sv
module ramclk_ctrl
  import ramclk_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic              coreClk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic              zzEn,
  input  logic              lowPower,
  input  logic              periodStart,
  output dpCtrl_t           strobes,
  output logic              ratioValid,
  output logic              dllEn,
  output logic              clkStable,
  output logic              ramZz
);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);

  logic [CODE_W-1:0] activeCode;
  logic [CODE_W-1:0] effCode;
  logic [HALF_W-1:0] effHalf;
  logic [LCW-1:0]    lockCnt;
  logic              codeSwap;

  // A new code is only taken at a period boundary.
  always_comb begin
    effCode  = periodStart ? ratioCode : activeCode;
    effHalf  = halfLenOf(effCode);
    codeSwap = periodStart && (ratioCode != activeCode);
    strobes.run     = (effHalf != '0);
    strobes.halfLen = effHalf;
    strobes.highLen = HALF_W'((effHalf + HALF_W'(1)) >> 1);
  end

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= RC_OFF;
      lockCnt    <= '0;
      ramZz      <= 1'b0;
    end else begin
      activeCode <= effCode;
      ramZz      <= zzEn && lowPower;
      if (!strobes.run || codeSwap)
        lockCnt <= '0;
      else if (lockCnt != LCW'(LOCK_CYCLES))
        lockCnt <= lockCnt + LCW'(1);
    end
  end

  assign ratioValid = (halfLenOf(activeCode) != '0);
  assign dllEn      = ratioValid;
  assign clkStable  = (lockCnt == LCW'(LOCK_CYCLES));

  // R6: the code in effect only moves at a period boundary
  p_hold_code_r6: assert property (@(posedge coreClk) disable iff (!rstN)
    !periodStart |=> $stable(activeCode));
  // R10: a stable flag implies a dividing code is applied
  p_stable_valid_r10: assert property (@(posedge coreClk) disable iff (!rstN)
    clkStable |-> ratioValid);
  // R9: sleep request follows one cycle after an enabled low-power mode
  p_zz_follow_r9: assert property (@(posedge coreClk) disable iff (!rstN)
    (zzEn && lowPower) |=> ramZz);
  // R9: no sleep request without its enable
  p_zz_off_r9: assert property (@(posedge coreClk) disable iff (!rstN)
    !zzEn |=> !ramZz);
endmodule

// File: rtl/ramclk_dp.sv
module ramclk_dp
  import ramclk_pkg::*;
(
  input  logic    coreClk,
  input  logic    rstN,
  input  dpCtrl_t strobes,
  input  logic    gateReq,
  output logic    periodStart,
  output logic    divClkEn,
  output logic    ramClk
);
  logic [HALF_W-1:0] idx;
  logic [HALF_W-1:0] idx1;
  logic [HALF_W-1:0] idx2;
  logic              posBit;
  logic              negPending;
  logic              negBit;

  // Positions of the two half-periods in this core cycle and the next one.
  always_comb begin
    idx1 = (idx + HALF_W'(1) == strobes.halfLen) ? '0 : idx + HALF_W'(1);
    idx2 = (idx1 + HALF_W'(1) == strobes.halfLen) ? '0 : idx1 + HALF_W'(1);
  end

  assign periodStart = (idx == '0);

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      idx        <= '0;
      posBit     <= 1'b0;
      negPending <= 1'b0;
      divClkEn   <= 1'b0;
    end else if (!strobes.run) begin
      idx        <= '0;
      posBit     <= 1'b0;
      negPending <= 1'b0;
      divClkEn   <= 1'b0;
    end else begin
      idx        <= idx2;
      posBit     <= (idx  < strobes.highLen);
      negPending <= (idx1 < strobes.highLen);
      divClkEn   <= periodStart;
    end
  end

  // Second half of each core cycle is retimed on the falling edge.
  always_ff @(negedge coreClk or negedge rstN) begin
    if (!rstN) negBit <= 1'b0;
    else       negBit <= negPending;
  end

  assign ramClk = (coreClk ? posBit : negBit) && !gateReq;

  // R3: position never leaves the period selected by the control
  p_idx_range_r3: assert property (@(posedge coreClk) disable iff (!rstN)
    strobes.run |-> (idx < strobes.halfLen));
  // R4: a period begins with its high phase
  p_start_high_r4: assert property (@(posedge coreClk) disable iff (!rstN)
    divClkEn |-> posBit);
  // R2: stopping leaves the pattern low
  p_stop_low_r2: assert property (@(posedge coreClk) disable iff (!rstN)
    !strobes.run |=> (!posBit && !negPending));
endmodule

// File: rtl/ramclk_gen.sv
module ramclk_gen
  import ramclk_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic       coreClk,
  input  logic       rstN,
  input  logic [2:0] ratioCode,
  input  logic       clkStopEn,
  input  logic       zzEn,
  input  logic       napMode,
  input  logic       sleepMode,
  output logic       divClkEn,
  output logic       ramClk,
  output logic       ramZz,
  output logic       ratioValid,
  output logic       dllEn,
  output logic       clkStable
);
  dpCtrl_t strobes;
  logic    periodStart;
  logic    lowPower;

  assign lowPower = napMode || sleepMode;

  ramclk_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .coreClk    (coreClk),
    .rstN       (rstN),
    .ratioCode  (ratioCode),
    .zzEn       (zzEn),
    .lowPower   (lowPower),
    .periodStart(periodStart),
    .strobes    (strobes),
    .ratioValid (ratioValid),
    .dllEn      (dllEn),
    .clkStable  (clkStable),
    .ramZz      (ramZz)
  );

  ramclk_dp u_dp (
    .coreClk    (coreClk),
    .rstN       (rstN),
    .strobes    (strobes),
    .gateReq    (clkStopEn && lowPower),
    .periodStart(periodStart),
    .divClkEn   (divClkEn),
    .ramClk     (ramClk)
  );
endmodule

// File: tb/ramclk_gen_bench.sv
module ramclk_gen_bench;
  logic       coreClk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] ratioCode = 3'b000;
  logic       clkStopEn = 1'b0, zzEn = 1'b0, napMode = 1'b0, sleepMode = 1'b0;
  logic       divClkEn, ramClk, ramZz, ratioValid, dllEn, clkStable;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #4 coreClk = ~coreClk;

  ramclk_gen #(.LOCK_CYCLES(64)) u_ramclk_gen (
    .coreClk(coreClk), .rstN(rstN), .ratioCode(ratioCode),
    .clkStopEn(clkStopEn), .zzEn(zzEn), .napMode(napMode), .sleepMode(sleepMode),
    .divClkEn(divClkEn), .ramClk(ramClk), .ramZz(ramZz),
    .ratioValid(ratioValid), .dllEn(dllEn), .clkStable(clkStable)
  );

  // {code, valid, half-periods}
  localparam logic [6:0] VEC [0:7] = '{
    {3'b001, 1'b1, 3'd2}, {3'b010, 1'b1, 3'd3}, {3'b100, 1'b1, 3'd4},
    {3'b101, 1'b1, 3'd5}, {3'b110, 1'b1, 3'd6}, {3'b011, 1'b0, 3'd0},
    {3'b111, 1'b0, 3'd0}, {3'b000, 1'b0, 3'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic midHi(); @(posedge coreClk); #2; endtask
  task automatic midLo(); @(negedge coreClk); #2; endtask

  // Wait for a period start; returns 1 if seen.
  task automatic waitStart(output bit seen);
    seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      midHi();
      if (divClkEn) seen = 1;
    end
  endtask

  // Compare two output periods starting at the current high half.
  task automatic checkPattern(input int h, input string tag);
    int bad = 0, lastAct = 0, lastExp = 0;
    int hi = (h + 1) / 2;
    for (int k = 0; k < 2 * h; k++) begin
      if (k != 0) begin
        if (k % 2 == 1) midLo(); else midHi();
      end
      if (ramClk !== ((k % h) < hi)) begin
        bad++; lastAct = ramClk; lastExp = ((k % h) < hi);
      end
    end
    check(bad == 0, tag, lastAct, lastExp);
  endtask

  task automatic checkLowFor(input int halves, input string tag);
    int highs = 0;
    for (int k = 0; k < halves; k++) begin
      if (k % 2 == 0) midHi(); else midLo();
      if (ramClk !== 1'b0) highs++;
    end
    check(highs == 0, tag, highs, 0);
  endtask

  task automatic countHighs(input int halves, output int highs);
    highs = 0;
    for (int k = 0; k < halves; k++) begin
      if (k % 2 == 0) midHi(); else midLo();
      if (ramClk === 1'b1) highs++;
    end
  endtask

  initial begin
    bit seen;
    int highs;
    // R1 reset state
    midHi();
    check(ramClk == 0 && divClkEn == 0 && ramZz == 0, "R1 outputs in reset", ramClk, 0);
    check(ratioValid == 0 && dllEn == 0 && clkStable == 0, "R1 flags in reset", ratioValid, 0);
    rstN = 1'b1;
    midHi(); midHi();
    check(ratioValid == 0 && clkStable == 0, "R1 flags after reset", ratioValid, 0);
    checkLowFor(8, "R2 code 000 keeps clock low");
    check(dllEn == 0, "R2 dllEn low when stopped", dllEn, 0);

    // Table walk: R3 R4 R5 R7
    foreach (VEC[i]) begin
      ratioCode = VEC[i][6:4];
      if (VEC[i][3]) begin
        waitStart(seen);
        check(seen, $sformatf("R4 period start code %0b", VEC[i][6:4]), seen, 1);
        check(ratioValid && dllEn, $sformatf("R7 valid code %0b", VEC[i][6:4]), ratioValid, 1);
        checkPattern(VEC[i][2:0], $sformatf("R3 pattern code %0b", VEC[i][6:4]));
      end else begin
        repeat (8) midHi();
        check(!ratioValid && !dllEn, $sformatf("R5 invalid code %0b", VEC[i][6:4]), ratioValid, 0);
        checkLowFor(8, $sformatf("R5 stopped code %0b", VEC[i][6:4]));
      end
    end

    // R6 boundary switch from ratio 3 to ratio 1
    ratioCode = 3'b110;
    waitStart(seen);
    waitStart(seen);
    ratioCode = 3'b001;
    midHi(); check(ramClk == 1, "R6 old pattern half 2", ramClk, 1);
    midLo(); check(ramClk == 0, "R6 old pattern half 3", ramClk, 0);
    midHi(); check(ramClk == 0 && divClkEn == 0, "R6 old pattern half 4", ramClk, 0);
    midLo();
    midHi(); check(ramClk == 1 && divClkEn == 1, "R6 new period start", ramClk, 1);
    checkPattern(2, "R6 new pattern");

    // R8 clock stop gating
    clkStopEn = 1'b1; napMode = 1'b1;
    checkLowFor(8, "R8 gated in nap");
    napMode = 1'b0; sleepMode = 1'b1;
    checkLowFor(6, "R8 gated in sleep");
    sleepMode = 1'b0;
    countHighs(8, highs);
    check(highs == 4, "R8 resumes after exit", highs, 4);
    clkStopEn = 1'b0; napMode = 1'b1;
    countHighs(8, highs);
    check(highs == 4, "R8 no gating without enable", highs, 4);
    napMode = 1'b0;

    // R9 ZZ
    zzEn = 1'b1;
    midHi();
    check(ramZz == 0, "R9 zz low when awake", ramZz, 0);
    sleepMode = 1'b1;
    midLo();
    check(ramZz == 0, "R9 zz not before edge", ramZz, 0);
    midHi();
    check(ramZz == 1, "R9 zz asserted", ramZz, 1);
    sleepMode = 1'b0;
    midHi();
    check(ramZz == 0, "R9 zz released", ramZz, 0);
    zzEn = 1'b0; napMode = 1'b1;
    midHi(); midHi();
    check(ramZz == 0, "R9 zz ignored without enable", ramZz, 0);
    napMode = 1'b0;

    // R10 lock wait
    ratioCode = 3'b000;
    repeat (8) midHi();
    check(clkStable == 0, "R10 cleared when stopped", clkStable, 0);
    ratioCode = 3'b100;
    repeat (60) midHi();
    check(clkStable == 0, "R10 not stable early", clkStable, 0);
    repeat (10) midHi();
    check(clkStable == 1, "R10 stable after wait", clkStable, 1);
    ratioCode = 3'b101;
    repeat (6) midHi();
    check(clkStable == 0, "R10 cleared on code change", clkStable, 0);
    ratioCode = 3'b011;
    repeat (80) midHi();
    check(clkStable == 0, "R10 never stable on reserved", clkStable, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule